// File: doc/BRIEF.md
# Vector Chaining Issue Unit

This block is a small vector execution core. It holds a short program of three-operand vector instructions in an instruction buffer and issues them in program order, at most one per clock. Each instruction is an element-wise add or multiply over two source vector registers, and it writes a destination vector register. An issued instruction takes a free pipelined functional unit. That unit then streams one element result per cycle into the destination register. Integer add and multiply stand in for floating-point arithmetic.

A later instruction that reads a register still being produced does not wait for the whole vector. It chains onto the producer and consumes element i one cycle after element i is written, so several units stream at once while issue stays at one instruction per cycle. Issue holds an instruction that needs a busy unit kind, or that would overwrite a register still being read or written by an active unit. The host preloads the vector registers and the instruction buffer while the core is idle. It then pulses `start` with a program length and a vector length, and waits for `done`.

Top module: `vcu_chain_core`

## Requirements
- R1: After reset the core is idle: `issue_valid`, every `wr_valid` bit and `done` are low.
- R2: At most one instruction issues per cycle, in program order. `issue_pc` counts 0, 1, 2, ... across successive issues, starting at 0 in the cycle after `start`.
- R3: When its sources are ready, an add issued in cycle t writes element 0 in cycle t+3. It then writes one further element per cycle, in index order.
- R4: A multiply issued in cycle t with ready sources writes element 0 in cycle t+4, then one element per cycle.
- R5: A unit reads element i of a source that another active unit is producing no earlier than the cycle after that element's write strobe. It does not wait for the rest of the vector.
- R6: The core has two add units and one multiply unit. Issue picks the lowest-numbered free unit of the needed kind (add units 0 and 1, multiply unit 2). It stalls while none is free. A unit is free from the cycle after its last element write.
- R7: Issue stalls while the destination register is a source of an active unit that has not yet read all of its elements.
- R8: Issue stalls while the destination register is the destination of an active unit.
- R9: Every instruction processes exactly `vlen` elements (1 to 16), the value captured at `start`.
- R10: `done` is a one-cycle pulse in the first cycle in which every instruction has issued and all units are idle.
- R11: Instruction encoding: bit 9 is the operation (0 add, 1 multiply), bits 8:6 the destination, bits 5:3 the first source and bits 2:0 the second source. Results are the low 32 bits of the sum or product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_we | input | 1 | Write strobe for the instruction buffer |
| load_addr | input | 4 | Instruction buffer write slot |
| load_instr | input | 10 | Instruction word to store |
| init_we | input | 1 | Host write strobe for one vector register element |
| init_reg | input | 3 | Register written by the host |
| init_idx | input | 4 | Element written by the host |
| init_data | input | 32 | Element value written by the host |
| start | input | 1 | Begin running the buffered program |
| prog_len | input | 5 | Number of instructions to run, sampled at start |
| vlen | input | 5 | Vector length 1..16, sampled at start |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_pc | output | 4 | Buffer slot of the issuing instruction |
| wr_valid | output | 3 | Per-unit element write strobe |
| wr_reg | output | 9 | Per-unit destination register, 3 bits per unit |
| wr_idx | output | 12 | Per-unit element index, 4 bits per unit |
| wr_data | output | 96 | Per-unit element result, 32 bits per unit |
| done | output | 1 | Program finished pulse |

## Verification
The assertions take the host side as well behaved. `start` arrives only while the core is idle and carries a vector length between 1 and 16. The instruction buffer and the register preload are written only while no program runs. Under these conditions the hazard rules keep two active units from sharing a destination, and the in-core checks depend on that. The stimulus loads registers and programs only between runs, waits for `done` plus a few idle cycles before each new `start`, and uses only the legal lengths 1, 3, 4, 5, 6, 8 and 16.

// File: rtl/vcu_pkg.sv
// Shared sizes and the instruction word layout for the vector chaining core.
// Assumes a power-of-two register count and element count.
package vcu_pkg;
    parameter int NREG  = 8;
    parameter int NELEM = 16;
    parameter int DW    = 32;
    localparam int RW = $clog2(NREG);
    localparam int EW = $clog2(NELEM);
    localparam int CW = EW + 1;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } vop_e;

    typedef struct packed {
        vop_e          op;
        logic [RW-1:0] vd;
        logic [RW-1:0] va;
        logic [RW-1:0] vb;
    } vinstr_t;

    localparam int IW = $bits(vinstr_t);
endpackage

// File: rtl/vcu_ibuf.sv
// Instruction buffer: host-written store of instruction words, read
// combinationally at the program address. Assumes writes only while idle.
module vcu_ibuf
    import vcu_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [IW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [IW-1:0] rdata
);
    logic [IW-1:0] mem [DEPTH];

    // Store a host-supplied instruction word.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the word at the program address.
    assign rdata = mem[raddr];
endmodule

// File: rtl/vcu_vrf.sv
// Vector register file: one host write port, one write port per functional
// unit, and two combinational read ports per unit. Assumes no two writers
// target the same element in one cycle (guaranteed by issue hazards).
module vcu_vrf
    import vcu_pkg::*;
#(
    parameter int NP = 3
) (
    input  logic          clk,
    input  logic          init_we,
    input  logic [RW-1:0] init_reg,
    input  logic [EW-1:0] init_idx,
    input  logic [DW-1:0] init_data,
    input  logic [RW-1:0] rd_reg  [NP*2],
    input  logic [EW-1:0] rd_idx  [NP*2],
    output logic [DW-1:0] rd_data [NP*2],
    input  logic [NP-1:0] wr_en,
    input  logic [RW-1:0] wr_reg  [NP],
    input  logic [EW-1:0] wr_idx  [NP],
    input  logic [DW-1:0] wr_data [NP]
);
    logic [DW-1:0] mem [NREG][NELEM];

    // Apply the host preload and all unit element writes.
    always_ff @(posedge clk) begin
        if (init_we) mem[init_reg][init_idx] <= init_data;
        for (int p = 0; p < NP; p++) begin
            if (wr_en[p]) mem[wr_reg[p]][wr_idx[p]] <= wr_data[p];
        end
    end

    for (genvar q = 0; q < NP*2; q++) begin : g_rd
        // Operand read for one unit source.
        assign rd_data[q] = mem[rd_reg[q]][rd_idx[q]];
    end
endmodule

// File: rtl/vcu_fu.sv
// Pipelined vector functional unit. After issue it reads one element pair
// per cycle whenever both source elements are ready, and delivers each
// result LAT-1 cycles after its read. It stays busy until the last element
// is written. Assumes LAT >= 2 and that issue arrives only while idle.
module vcu_fu
    import vcu_pkg::*;
#(
    parameter int LAT    = 3,
    parameter bit IS_MUL = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          issue_go,
    input  logic [RW-1:0] iss_vd,
    input  logic [RW-1:0] iss_va,
    input  logic [RW-1:0] iss_vb,
    input  logic [CW-1:0] vlen,
    input  logic          ready_a,
    input  logic          ready_b,
    input  logic [DW-1:0] opnd_a,
    input  logic [DW-1:0] opnd_b,
    output logic          busy,
    output logic          reading,
    output logic [RW-1:0] dst,
    output logic [RW-1:0] src_a,
    output logic [RW-1:0] src_b,
    output logic [CW-1:0] rcnt,
    output logic [CW-1:0] wcnt,
    output logic          wr_en,
    output logic [EW-1:0] wr_idx,
    output logic [DW-1:0] wr_data
);
    localparam int STG = LAT - 1;

    logic          st_v [STG];
    logic [EW-1:0] st_i [STG];
    logic [DW-1:0] st_d [STG];
    logic          fire;
    logic [DW-1:0] result;

    // Element reads remain while the read counter is short of the length.
    assign reading = busy && (rcnt < vlen);
    // Read the next element pair once both sources have it.
    assign fire    = reading && ready_a && ready_b;
    // Arithmetic for this unit kind, low DW bits kept.
    assign result  = IS_MUL ? (opnd_a * opnd_b) : (opnd_a + opnd_b);

    // Issue capture, read/write counters and busy lifetime.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            rcnt  <= '0;
            wcnt  <= '0;
            dst   <= '0;
            src_a <= '0;
            src_b <= '0;
        end else if (issue_go) begin
            busy  <= 1'b1;
            rcnt  <= '0;
            wcnt  <= '0;
            dst   <= iss_vd;
            src_a <= iss_va;
            src_b <= iss_vb;
        end else begin
            if (fire) rcnt <= rcnt + 1'b1;
            if (wr_en) begin
                wcnt <= wcnt + 1'b1;
                if (wcnt == vlen - 1'b1) busy <= 1'b0;
            end
        end
    end

    // Valid bits of the result pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < STG; k++) st_v[k] <= 1'b0;
        end else begin
            st_v[0] <= fire;
            for (int k = 1; k < STG; k++) st_v[k] <= st_v[k-1];
        end
    end

    // Index and data of the result pipeline.
    always_ff @(posedge clk) begin
        st_i[0] <= rcnt[EW-1:0];
        st_d[0] <= result;
        for (int k = 1; k < STG; k++) begin
            st_i[k] <= st_i[k-1];
            st_d[k] <= st_d[k-1];
        end
    end

    assign wr_en   = st_v[STG-1];
    assign wr_idx  = st_i[STG-1];
    assign wr_data = st_d[STG-1];

    // R6: a unit is only handed an instruction while free.
    assert_issue_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
        issue_go |-> !busy);
    // R3: results leave in index order, counted independently of the pipeline.
    assert_write_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx == wcnt[EW-1:0]));
    // R5: a write never overtakes the read that produced it.
    assert_read_ahead_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wcnt < rcnt));
endmodule

// File: rtl/vcu_chain_core.sv
// Single-issue vector core with operand chaining. Issues the instruction at
// the program address when a unit of its kind is free and no active unit
// still reads or writes its destination. Per-element readiness comes from
// comparing producer write counters with consumer read counters. Assumes
// host loads and start only while idle, with vlen in 1..NELEM.
module vcu_chain_core
    import vcu_pkg::*;
#(
    parameter int N_ADD      = 2,
    parameter int N_MUL      = 1,
    parameter int LAT_ADD    = 3,
    parameter int LAT_MUL    = 4,
    parameter int PROG_DEPTH = 16,
    localparam int NU  = N_ADD + N_MUL,
    localparam int PAW = $clog2(PROG_DEPTH),
    localparam int PLW = PAW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_we,
    input  logic [PAW-1:0]   load_addr,
    input  logic [IW-1:0]    load_instr,
    input  logic             init_we,
    input  logic [RW-1:0]    init_reg,
    input  logic [EW-1:0]    init_idx,
    input  logic [DW-1:0]    init_data,
    input  logic             start,
    input  logic [PLW-1:0]   prog_len,
    input  logic [CW-1:0]    vlen,
    output logic             issue_valid,
    output logic [PAW-1:0]   issue_pc,
    output logic [NU-1:0]    wr_valid,
    output logic [NU*RW-1:0] wr_reg,
    output logic [NU*EW-1:0] wr_idx,
    output logic [NU*DW-1:0] wr_data,
    output logic             done
);
    localparam int UW = (NU > 1) ? $clog2(NU) : 1;

    logic           running;
    logic [PLW-1:0] pc;
    logic [PLW-1:0] len_q;
    logic [CW-1:0]  vl_q;
    logic [IW-1:0]  ibuf_q;
    vinstr_t        cur;

    logic [NU-1:0]  u_busy, u_reading, u_go, u_wen, rdy_a, rdy_b;
    logic [RW-1:0]  u_dst [NU];
    logic [RW-1:0]  u_sa  [NU];
    logic [RW-1:0]  u_sb  [NU];
    logic [CW-1:0]  u_rcnt [NU];
    logic [CW-1:0]  u_wcnt [NU];
    logic [EW-1:0]  u_widx [NU];
    logic [DW-1:0]  u_wdat [NU];
    logic [RW-1:0]  rf_rreg [NU*2];
    logic [EW-1:0]  rf_ridx [NU*2];
    logic [DW-1:0]  rf_rdat [NU*2];

    logic           sel_ok, war, waw;
    logic [UW-1:0]  sel_u;

    vcu_ibuf #(.DEPTH(PROG_DEPTH)) u_ibuf (
        .clk   (clk),
        .we    (load_we),
        .waddr (load_addr),
        .wdata (load_instr),
        .raddr (pc[PAW-1:0]),
        .rdata (ibuf_q)
    );

    assign cur = vinstr_t'(ibuf_q);

    vcu_vrf #(.NP(NU)) u_vrf (
        .clk       (clk),
        .init_we   (init_we),
        .init_reg  (init_reg),
        .init_idx  (init_idx),
        .init_data (init_data),
        .rd_reg    (rf_rreg),
        .rd_idx    (rf_ridx),
        .rd_data   (rf_rdat),
        .wr_en     (u_wen),
        .wr_reg    (u_dst),
        .wr_idx    (u_widx),
        .wr_data   (u_wdat)
    );

    for (genvar u = 0; u < NU; u++) begin : g_unit
        localparam bit UMUL = (u >= N_ADD);
        localparam int ULAT = UMUL ? LAT_MUL : LAT_ADD;

        vcu_fu #(.LAT(ULAT), .IS_MUL(UMUL)) u_fu (
            .clk      (clk),
            .rst_n    (rst_n),
            .issue_go (u_go[u]),
            .iss_vd   (cur.vd),
            .iss_va   (cur.va),
            .iss_vb   (cur.vb),
            .vlen     (vl_q),
            .ready_a  (rdy_a[u]),
            .ready_b  (rdy_b[u]),
            .opnd_a   (rf_rdat[2*u]),
            .opnd_b   (rf_rdat[2*u+1]),
            .busy     (u_busy[u]),
            .reading  (u_reading[u]),
            .dst      (u_dst[u]),
            .src_a    (u_sa[u]),
            .src_b    (u_sb[u]),
            .rcnt     (u_rcnt[u]),
            .wcnt     (u_wcnt[u]),
            .wr_en    (u_wen[u]),
            .wr_idx   (u_widx[u]),
            .wr_data  (u_wdat[u])
        );

        // Route the unit's source registers and next element to the file.
        assign rf_rreg[2*u]   = u_sa[u];
        assign rf_rreg[2*u+1] = u_sb[u];
        assign rf_ridx[2*u]   = u_rcnt[u][EW-1:0];
        assign rf_ridx[2*u+1] = u_rcnt[u][EW-1:0];
        // Hand the issuing instruction to the selected unit.
        assign u_go[u] = issue_valid && (sel_u == UW'(u));
        // Flatten the unit's write stream onto the outputs.
        assign wr_valid[u]          = u_wen[u];
        assign wr_reg[u*RW +: RW]   = u_dst[u];
        assign wr_idx[u*EW +: EW]   = u_widx[u];
        assign wr_data[u*DW +: DW]  = u_wdat[u];
    end

    // Chaining readiness: a source element waits for any other active
    // producer of that register whose write count has not passed it.
    always_comb begin
        rdy_a = '1;
        rdy_b = '1;
        for (int u = 0; u < NU; u++) begin
            for (int w = 0; w < NU; w++) begin
                if (w != u && u_busy[w] && (u_wcnt[w] <= u_rcnt[u])) begin
                    if (u_dst[w] == u_sa[u]) rdy_a[u] = 1'b0;
                    if (u_dst[w] == u_sb[u]) rdy_b[u] = 1'b0;
                end
            end
        end
    end

    // Pick the lowest-numbered free unit of the instruction's kind.
    always_comb begin
        sel_ok = 1'b0;
        sel_u  = '0;
        for (int u = NU - 1; u >= 0; u--) begin
            if (!u_busy[u] && ((u >= N_ADD) == (cur.op == OP_MUL))) begin
                sel_ok = 1'b1;
                sel_u  = UW'(u);
            end
        end
    end

    // Destination hazards against active units.
    always_comb begin
        war = 1'b0;
        waw = 1'b0;
        for (int w = 0; w < NU; w++) begin
            if (u_busy[w] && u_dst[w] == cur.vd) waw = 1'b1;
            if (u_reading[w] && (u_sa[w] == cur.vd || u_sb[w] == cur.vd)) war = 1'b1;
        end
    end

    assign issue_valid = running && (pc < len_q) && sel_ok && !war && !waw;
    assign issue_pc    = pc[PAW-1:0];
    assign done        = running && (pc == len_q) && !(|u_busy);

    // Run control and program address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pc      <= '0;
            len_q   <= '0;
            vl_q    <= '0;
        end else if (!running) begin
            if (start) begin
                running <= 1'b1;
                pc      <= '0;
                len_q   <= prog_len;
                vl_q    <= vlen;
            end
        end else begin
            if (issue_valid) pc <= pc + 1'b1;
            if (done) running <= 1'b0;
        end
    end

    // R2: one unit at most receives an instruction per cycle.
    assert_single_go_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(u_go));
    // R2: each issue advances the program address by one.
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue_valid |=> (pc == $past(pc) + 1'b1));
    // R10: completion is a single-cycle pulse.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R9: input assumption, legal vector length at start.
    assert_vlen_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !running) |-> (vlen != '0 && vlen <= CW'(NELEM)));

    for (genvar a = 0; a < NU; a++) begin : g_waw_a
        for (genvar b = a + 1; b < NU; b++) begin : g_waw_b
            // R8: two active units never share a destination.
            assert_no_waw_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !(u_busy[a] && u_busy[b] && u_dst[a] == u_dst[b]));
        end
    end
endmodule

// File: tb/vcu_chain_core_bench.sv
`timescale 1ns/1ps
// Bench: behavioural schedule model (per-element availability times and
// hazard windows as integers) compared with the core on every clock.
module vcu_chain_core_bench;
    localparam int NU = 3;
    localparam int MAXC = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_we = 1'b0;
    logic [3:0]  load_addr = '0;
    logic [9:0]  load_instr = '0;
    logic        init_we = 1'b0;
    logic [2:0]  init_reg = '0;
    logic [3:0]  init_idx = '0;
    logic [31:0] init_data = '0;
    logic        start = 1'b0;
    logic [4:0]  prog_len = '0;
    logic [4:0]  vlen = '0;
    logic        issue_valid;
    logic [3:0]  issue_pc;
    logic [2:0]  wr_valid;
    logic [8:0]  wr_reg;
    logic [11:0] wr_idx;
    logic [95:0] wr_data;
    logic        done;

    vcu_chain_core u_vcu_chain_core (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
        .load_instr(load_instr), .init_we(init_we), .init_reg(init_reg),
        .init_idx(init_idx), .init_data(init_data), .start(start),
        .prog_len(prog_len), .vlen(vlen), .issue_valid(issue_valid),
        .issue_pc(issue_pc), .wr_valid(wr_valid), .wr_reg(wr_reg),
        .wr_idx(wr_idx), .wr_data(wr_data), .done(done)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int failures = 0;
    int wd = 0;

    logic [31:0] vr [8][16];
    logic [9:0]  prog [16];
    logic        exp_iv [MAXC];
    int          exp_ipc [MAXC];
    logic        exp_done [MAXC];
    logic        exp_wv [MAXC][NU];
    logic [2:0]  exp_wr [MAXC][NU];
    logic [3:0]  exp_wi [MAXC][NU];
    logic [31:0] exp_wd [MAXC][NU];

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 50000) begin
            failures = failures + 1;
            $display("FAIL watchdog expired act=%0d exp<=50000", wd);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int cyc, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s cycle %0d act=%0h exp=%0h", tag, what, cyc, act, exp);
        end
    endtask

    function automatic logic [9:0] enc(input bit mul, input int d, input int a, input int b);
        return {mul, 3'(d), 3'(a), 3'(b)};
    endfunction

    // Build the expected per-cycle schedule for prog[0..n-1] at length vl.
    task automatic build_model(input int n, input int vl);
        int ufree [NU];
        int avail [8][16];
        int lrd [8];
        int lwr [8];
        int rd [16];
        logic [31:0] tmp [16];
        int prev, dmax, c, u, lat, wl;
        bit found;
        for (int k = 0; k < MAXC; k++) begin
            exp_iv[k] = 1'b0;
            exp_ipc[k] = 0;
            exp_done[k] = 1'b0;
            for (int q = 0; q < NU; q++) exp_wv[k][q] = 1'b0;
        end
        for (int q = 0; q < NU; q++) ufree[q] = 0;
        for (int r = 0; r < 8; r++) begin
            lrd[r] = -1;
            lwr[r] = -1;
            for (int i = 0; i < 16; i++) avail[r][i] = 0;
        end
        prev = -1;
        dmax = 0;
        for (int k = 0; k < n; k++) begin
            bit mul;
            int d, a, b;
            mul = prog[k][9];
            d = int'(prog[k][8:6]);
            a = int'(prog[k][5:3]);
            b = int'(prog[k][2:0]);
            lat = mul ? 4 : 3;
            c = prev + 1;
            found = 1'b0;
            u = -1;
            while (!found) begin
                u = -1;
                for (int q = NU - 1; q >= 0; q--)
                    if (((q >= 2) == mul) && ufree[q] <= c) u = q;
                if (u >= 0 && c > lrd[d] && c > lwr[d]) found = 1'b1;
                else c++;
            end
            exp_iv[c] = 1'b1;
            exp_ipc[c] = k;
            prev = c;
            for (int i = 0; i < vl; i++) begin
                int r;
                r = (i == 0) ? c + 1 : rd[i-1] + 1;
                if (avail[a][i] > r) r = avail[a][i];
                if (avail[b][i] > r) r = avail[b][i];
                rd[i] = r;
                tmp[i] = mul ? vr[a][i] * vr[b][i] : vr[a][i] + vr[b][i];
            end
            wl = 0;
            for (int i = 0; i < vl; i++) begin
                int w;
                w = rd[i] + lat - 1;
                exp_wv[w][u] = 1'b1;
                exp_wr[w][u] = 3'(d);
                exp_wi[w][u] = 4'(i);
                exp_wd[w][u] = tmp[i];
                avail[d][i] = w + 1;
                vr[d][i] = tmp[i];
                wl = w;
            end
            if (rd[vl-1] > lrd[a]) lrd[a] = rd[vl-1];
            if (rd[vl-1] > lrd[b]) lrd[b] = rd[vl-1];
            lwr[d] = wl;
            ufree[u] = wl + 1;
            if (wl + 1 > dmax) dmax = wl + 1;
        end
        exp_done[dmax] = 1'b1;
    endtask

    // Load, start, and compare every cycle until shortly after completion.
    task automatic run_prog(input int n, input int vl, input string tag);
        int last;
        for (int k = 0; k < n; k++) begin
            load_we = 1'b1;
            load_addr = 4'(k);
            load_instr = prog[k];
            @(negedge clk);
        end
        load_we = 1'b0;
        build_model(n, vl);
        last = 0;
        for (int k = 0; k < MAXC; k++) if (exp_done[k]) last = k;
        start = 1'b1;
        prog_len = 5'(n);
        vlen = 5'(vl);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c <= last + 3; c++) begin
            chk(issue_valid == exp_iv[c], tag, "issue_valid", c, 32'(issue_valid), 32'(exp_iv[c]));
            if (exp_iv[c])
                chk(issue_pc == 4'(exp_ipc[c]), "R2", "issue_pc", c, 32'(issue_pc), 32'(exp_ipc[c]));
            chk(done == exp_done[c], "R10", "done", c, 32'(done), 32'(exp_done[c]));
            for (int q = 0; q < NU; q++) begin
                chk(wr_valid[q] == exp_wv[c][q], tag, "wr_valid", c, 32'(wr_valid[q]), 32'(exp_wv[c][q]));
                if (exp_wv[c][q] && wr_valid[q]) begin
                    chk(wr_reg[q*3 +: 3] == exp_wr[c][q], tag, "wr_reg", c,
                        32'(wr_reg[q*3 +: 3]), 32'(exp_wr[c][q]));
                    chk(wr_idx[q*4 +: 4] == exp_wi[c][q], "R3", "wr_idx", c,
                        32'(wr_idx[q*4 +: 4]), 32'(exp_wi[c][q]));
                    chk(wr_data[q*32 +: 32] == exp_wd[c][q], "R11", "wr_data", c,
                        wr_data[q*32 +: 32], exp_wd[c][q]);
                end
            end
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset.
        chk(issue_valid == 1'b0, "R1", "issue_valid", 0, 32'(issue_valid), 0);
        chk(wr_valid == 3'b000, "R1", "wr_valid", 0, 32'(wr_valid), 0);
        chk(done == 1'b0, "R1", "done", 0, 32'(done), 0);

        for (int r = 0; r < 8; r++) begin
            for (int i = 0; i < 16; i++) begin
                logic [31:0] v;
                v = 32'(r + 1) * 32'h0101_0101 + 32'(i) * 32'h9E37_79B1;
                vr[r][i] = v;
                init_we = 1'b1;
                init_reg = 3'(r);
                init_idx = 4'(i);
                init_data = v;
                @(negedge clk);
            end
        end
        init_we = 1'b0;

        // R3 / R9: lone add over the full length of 16.
        prog[0] = enc(0, 0, 1, 2);
        run_prog(1, 16, "R3");
        // R4: lone multiply, length 5.
        prog[0] = enc(1, 3, 1, 2);
        run_prog(1, 5, "R4");
        // R5: two adds chained into a multiply, length 8.
        prog[0] = enc(0, 0, 1, 2);
        prog[1] = enc(0, 3, 4, 5);
        prog[2] = enc(1, 6, 0, 3);
        run_prog(3, 8, "R5");
        // R6: more adds and multiplies than units, length 4.
        prog[0] = enc(0, 0, 1, 2);
        prog[1] = enc(0, 3, 4, 5);
        prog[2] = enc(0, 6, 1, 4);
        prog[3] = enc(1, 7, 2, 2);
        prog[4] = enc(1, 4, 7, 1);
        run_prog(5, 4, "R6");
        // R7: add overwrites a register a multiply is still reading.
        prog[0] = enc(1, 4, 1, 2);
        prog[1] = enc(0, 1, 5, 6);
        run_prog(2, 6, "R7");
        // R8: add targets a register a multiply is still writing.
        prog[0] = enc(1, 3, 1, 2);
        prog[1] = enc(0, 3, 4, 5);
        prog[2] = enc(0, 2, 3, 3);
        run_prog(3, 3, "R8");
        // R9: length 1 with a register reading itself.
        prog[0] = enc(0, 1, 1, 1);
        prog[1] = enc(1, 2, 1, 1);
        run_prog(2, 1, "R9");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule